// File: doc/BRIEF.md
# Warp Divergence Mask Sequencer

This block keeps the control state of one 32-thread warp in a SIMT core. It holds the warp program counter and the active-thread mask. It also holds a small stack of saved paths, so that a branch on which the threads disagree runs its two sides one after the other. Each thread is masked off while the side it did not choose is running. A branch on which all active threads agree changes only the program counter, and the warp continues on one path at full rate.

The datapath is eight lanes wide. Each accepted warp instruction is therefore issued as a series of lane-group beats. There is one beat for each group of eight threads that holds at least one active thread, and the groups go in ascending order. When the last beat ends, the instruction commits: the block moves the program counter and updates the mask and the stack. When the program counter then equals the rejoin address held in the top stack entry, the block pops that entry, one entry per cycle, before it accepts the next instruction.

Top module: `warp_mask_seq`

## Requirements
- R1: While `rst_n` is low the block loads `warp_pc` from `start_pc`, sets `active_mask` to all ones, empties the stack and clears `ovf_err`. After reset it is idle, with `ready` high and `busy` low.
- R2: An instruction with `is_branch` low is accepted when `instr_valid` is high and `ready` is high. After its beats, `warp_pc` becomes `next_pc` and `active_mask` is unchanged.
- R3: The cycle after acceptance, `busy` rises. There is one beat per cycle for each 8-lane group g (threads 8g to 8g+7) that holds at least one active thread, in ascending g. `beat_grp` is g and `beat_lanes` is that group's slice of the active mask. Groups with no active thread get no beat.
- R4: Let the taken set be `cond` AND `active_mask`. If the taken set is all zero, the branch goes to `fall_pc`. If it equals `active_mask`, the branch goes to `target_pc`. In both cases the mask and the stack are unchanged.
- R5: For any other taken set, the branch is divergent. `warp_pc` becomes `target_pc` and `active_mask` becomes the taken set. Two entries are pushed: first the rejoin entry (`reconv_pc` with the pre-branch mask), then the not-taken entry (`fall_pc` with the pre-branch mask AND NOT `cond`).
- R6: While the stack is not empty and `warp_pc` equals the rejoin address of the top entry, the block pops one entry per cycle and loads `warp_pc` and `active_mask` from it. `ready` stays low during these pops. Both entries of a divergent branch carry its `reconv_pc` as their rejoin address.
- R7: The stack holds DEPTH entries (default 8). A divergent branch that finds fewer than two free entries pushes nothing and still switches to its taken path. It sets `ovf_err`, which stays high until reset.
- R8: `instr_valid` has no effect while `ready` is low, and the instruction fields are sampled only in the cycle of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pc | input | 32 | Program counter loaded at reset |
| instr_valid | input | 1 | A warp instruction is offered |
| is_branch | input | 1 | The offered instruction is a branch |
| cond | input | 32 | Per-thread branch condition, bit t for thread t |
| target_pc | input | 32 | Branch taken address |
| fall_pc | input | 32 | Branch fall-through address |
| reconv_pc | input | 32 | Address where the two sides of the branch rejoin |
| next_pc | input | 32 | Successor address of a non-branch instruction |
| ready | output | 1 | Block will accept an instruction this cycle |
| busy | output | 1 | A lane-group beat is being issued |
| warp_pc | output | 32 | Current warp program counter |
| active_mask | output | 32 | Current active-thread mask |
| beat_grp | output | 2 | Lane group of the current beat |
| beat_lanes | output | 8 | Active lanes of the current beat |
| ovf_err | output | 1 | Sticky stack-overflow flag |

## Verification
The assertions take for granted that the active mask never becomes empty. This holds only if every branch that enters the stack is really divergent and every path goes on to reach the rejoin address it was given. Under that condition, every beat carries at least one lane and the group index strictly increases within an instruction. The stimulus follows well-formed control flow. Each divergent branch names a rejoin address that both of its sides later arrive at by a `next_pc` or a fall-through, and the overflow sequence only nests branches whose taken sets are non-empty proper subsets of the current mask.

// File: rtl/warp_mask_seq.sv
module warp_mask_seq #(
  parameter int WARP  = 32,
  parameter int LANES = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 32,
  localparam int GROUPS = WARP / LANES,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int SPW    = $clog2(DEPTH + 1),
  localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PCW-1:0]   start_pc,
  input  logic             instr_valid,
  input  logic             is_branch,
  input  logic [WARP-1:0]  cond,
  input  logic [PCW-1:0]   target_pc,
  input  logic [PCW-1:0]   fall_pc,
  input  logic [PCW-1:0]   reconv_pc,
  input  logic [PCW-1:0]   next_pc,
  output logic             ready,
  output logic             busy,
  output logic [PCW-1:0]   warp_pc,
  output logic [WARP-1:0]  active_mask,
  output logic [GW-1:0]    beat_grp,
  output logic [LANES-1:0] beat_lanes,
  output logic             ovf_err
);

  logic [PCW-1:0]  stk_pc   [DEPTH];
  logic [PCW-1:0]  stk_rpc  [DEPTH];
  logic [WARP-1:0] stk_mask [DEPTH];
  logic [SPW-1:0]  sp;
  logic [IW-1:0]   topi;

  logic            l_br;
  logic [WARP-1:0] l_cond;
  logic [PCW-1:0]  l_tgt, l_fall, l_rc, l_next;

  logic [GROUPS-1:0] nz;
  logic [GW-1:0]     first_g, nxt_g;
  logic              has_nxt;
  logic [WARP-1:0]   tmask;
  logic              room, pop_pending;

  assign topi        = IW'(sp - SPW'(1));
  assign pop_pending = (sp != '0) && (warp_pc == stk_rpc[topi]);
  assign ready       = !busy && !pop_pending;
  assign beat_lanes  = active_mask[beat_grp*LANES +: LANES];
  assign tmask       = l_cond & active_mask;
  assign room        = (int'(sp) + 2) <= DEPTH;

  for (genvar g = 0; g < GROUPS; g++) begin : g_nz
    assign nz[g] = |active_mask[g*LANES +: LANES];
  end

  always_comb begin
    first_g = '0;
    nxt_g   = '0;
    has_nxt = 1'b0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (nz[g]) first_g = GW'(g);
      if (nz[g] && g > int'(beat_grp)) begin
        nxt_g   = GW'(g);
        has_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warp_pc     <= start_pc;
      active_mask <= '1;
      sp          <= '0;
      busy        <= 1'b0;
      beat_grp    <= '0;
      ovf_err     <= 1'b0;
      l_br        <= 1'b0;
      l_cond      <= '0;
      l_tgt       <= '0;
      l_fall      <= '0;
      l_rc        <= '0;
      l_next      <= '0;
    end else if (busy) begin
      if (has_nxt) begin
        beat_grp <= nxt_g;
      end else begin
        busy <= 1'b0;
        if (!l_br) begin
          warp_pc <= l_next;
        end else if (tmask == '0) begin
          warp_pc <= l_fall;
        end else if (tmask == active_mask) begin
          warp_pc <= l_tgt;
        end else begin
          warp_pc     <= l_tgt;
          active_mask <= tmask;
          if (room) begin
            stk_pc[IW'(sp)]       <= l_rc;
            stk_rpc[IW'(sp)]      <= l_rc;
            stk_mask[IW'(sp)]     <= active_mask;
            stk_pc[IW'(sp + 1)]   <= l_fall;
            stk_rpc[IW'(sp + 1)]  <= l_rc;
            stk_mask[IW'(sp + 1)] <= active_mask & ~l_cond;
            sp <= sp + SPW'(2);
          end else begin
            ovf_err <= 1'b1;
          end
        end
      end
    end else if (pop_pending) begin
      warp_pc     <= stk_pc[topi];
      active_mask <= stk_mask[topi];
      sp          <= sp - SPW'(1);
    end else if (instr_valid) begin
      busy     <= 1'b1;
      beat_grp <= first_g;
      l_br     <= is_branch;
      l_cond   <= cond;
      l_tgt    <= target_pc;
      l_fall   <= fall_pc;
      l_rc     <= reconv_pc;
      l_next   <= next_pc;
    end
  end

  p_beat_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> beat_lanes != '0);

  p_grp_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> beat_grp > $past(beat_grp));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(active_mask));

  p_pop_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pop_pending |=> sp == $past(sp) - SPW'(1));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_sp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp) <= DEPTH);

  p_mask_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

endmodule

// File: tb/sim_warp_mask_seq.sv
module sim_warp_mask_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] start_pc = 32'h100;
  logic        instr_valid = 1'b0, is_branch = 1'b0;
  logic [31:0] cond = '0, target_pc = '0, fall_pc = '0, reconv_pc = '0, next_pc = '0;
  logic        ready, busy, ovf_err;
  logic [31:0] warp_pc, active_mask;
  logic [1:0]  beat_grp;
  logic [7:0]  beat_lanes;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  warp_mask_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_pc(start_pc), .instr_valid(instr_valid),
    .is_branch(is_branch), .cond(cond), .target_pc(target_pc), .fall_pc(fall_pc),
    .reconv_pc(reconv_pc), .next_pc(next_pc), .ready(ready), .busy(busy),
    .warp_pc(warp_pc), .active_mask(active_mask), .beat_grp(beat_grp),
    .beat_lanes(beat_lanes), .ovf_err(ovf_err)
  );

  typedef struct packed {
    logic        br;
    logic [31:0] c, t, f, r, n, epc, emask;
    logic [2:0]  ebeats;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h104, 32'h104, 32'hFFFFFFFF, 3'd4},
    '{1'b1, 32'hFFFFFFFF, 32'h200, 32'h108, 32'h0,   32'h0,   32'h200, 32'hFFFFFFFF, 3'd4},
    '{1'b1, 32'h0,        32'h250, 32'h204, 32'h0,   32'h0,   32'h204, 32'hFFFFFFFF, 3'd4},
    '{1'b1, 32'h0000FFFF, 32'h300, 32'h208, 32'h400, 32'h0,   32'h300, 32'h0000FFFF, 3'd4},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h304, 32'h304, 32'h0000FFFF, 3'd2},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h400, 32'h208, 32'hFFFF0000, 3'd2},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h20C, 32'h20C, 32'hFFFF0000, 3'd2},
    '{1'b1, 32'h0F0F0F0F, 32'h500, 32'h210, 32'h600, 32'h0,   32'h500, 32'h0F0F0000, 3'd2},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h600, 32'h210, 32'hF0F00000, 3'd2},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h600, 32'h600, 32'hFFFF0000, 3'd2},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h400, 32'h400, 32'hFFFFFFFF, 3'd2},
    '{1'b1, 32'h00000001, 32'h700, 32'h408, 32'h408, 32'h0,   32'h700, 32'h00000001, 3'd4},
    '{1'b1, 32'hFFFFFFFE, 32'h990, 32'h704, 32'h0,   32'h0,   32'h704, 32'h00000001, 3'd1},
    '{1'b1, 32'hFFFFFFFF, 32'h710, 32'h708, 32'h0,   32'h0,   32'h710, 32'h00000001, 3'd1},
    '{1'b0, 32'h0,        32'h0,   32'h0,   32'h0,   32'h408, 32'h408, 32'hFFFFFFFF, 3'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic run(input logic br, input logic [31:0] c, t, f, r, n,
                     input logic [31:0] epc, emask, input int ebeats, input string tag);
    logic [31:0] pre;
    int beats;
    int prev_g;
    wait_ready();
    pre = active_mask;
    is_branch = br; cond = c; target_pc = t; fall_pc = f; reconv_pc = r; next_pc = n;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    beats = 0;
    prev_g = -1;
    while (busy) begin
      chk(beat_lanes == pre[beat_grp*8 +: 8] && beat_lanes != 0 && int'(beat_grp) > prev_g,
          {"R3 beat lanes ", tag}, {22'd0, beat_grp, beat_lanes}, {22'd0, beat_grp, pre[beat_grp*8 +: 8]});
      prev_g = int'(beat_grp);
      beats++;
      @(negedge clk);
    end
    while (!ready) @(negedge clk);
    chk(beats == ebeats, {"R3 beat count ", tag}, beats, ebeats);
    chk(warp_pc == epc, {"pc ", tag}, warp_pc, epc);
    chk(active_mask == emask, {"mask ", tag}, active_mask, emask);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(warp_pc == 32'h100, "R1 reset pc", warp_pc, 32'h100);
    chk(active_mask == 32'hFFFFFFFF, "R1 reset mask", active_mask, 32'hFFFFFFFF);
    chk(ready && !busy && !ovf_err, "R1 reset idle", {29'd0, ready, busy, ovf_err}, 32'h4);

    // R2 R4 R5 R6 table: non-branch, uniform, divergent, nested and chained pops
    for (int i = 0; i < 15; i++) begin
      run(TBL[i].br, TBL[i].c, TBL[i].t, TBL[i].f, TBL[i].r, TBL[i].n,
          TBL[i].epc, TBL[i].emask, int'(TBL[i].ebeats), $sformatf("R2/R4/R5/R6 row%0d", i));
    end

    // R8: valid and changed fields while busy are ignored
    wait_ready();
    is_branch = 1'b0; next_pc = 32'h40C; instr_valid = 1'b1;
    @(negedge clk);
    is_branch = 1'b1; cond = '0; fall_pc = 32'hBAD; next_pc = 32'hBAD;
    @(negedge clk);
    instr_valid = 1'b0;
    while (!ready) @(negedge clk);
    chk(warp_pc == 32'h40C, "R8 ignore while busy", warp_pc, 32'h40C);
    repeat (3) @(negedge clk);
    chk(warp_pc == 32'h40C && ready, "R8 no second accept", warp_pc, 32'h40C);

    // R7 overflow
    rst_n = 1'b0; start_pc = 32'h0;
    @(negedge clk);
    rst_n = 1'b1;
    run(1'b1, 32'h0000FFFF, 32'h10, 32'h20, 32'hF00, 32'h0, 32'h10, 32'h0000FFFF, 4, "R7 push1");
    run(1'b1, 32'h000000FF, 32'h30, 32'h40, 32'hF10, 32'h0, 32'h30, 32'h000000FF, 2, "R7 push2");
    run(1'b1, 32'h0000000F, 32'h50, 32'h60, 32'hF20, 32'h0, 32'h50, 32'h0000000F, 1, "R7 push3");
    run(1'b1, 32'h00000003, 32'h70, 32'h80, 32'hF30, 32'h0, 32'h70, 32'h00000003, 1, "R7 push4");
    chk(!ovf_err, "R7 full no error", {31'd0, ovf_err}, 32'd0);
    run(1'b1, 32'h00000001, 32'h90, 32'hA0, 32'hF40, 32'h0, 32'h90, 32'h00000001, 1, "R7 overflow");
    chk(ovf_err, "R7 error set", {31'd0, ovf_err}, 32'd1);
    run(1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h94, 32'h94, 32'h00000001, 1, "R7 after");
    chk(ovf_err, "R7 error sticky", {31'd0, ovf_err}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ovf_err && active_mask == 32'hFFFFFFFF && warp_pc == 32'h0, "R1 reset clears",
        {31'd0, ovf_err}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule